// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Registers

This unit executes the integer multiply and divide operations of a 32-bit processor core. A start pulse, together with an operation code and two register operands, launches a signed or unsigned multiply or divide. The unit then works on it bit by bit for a fixed number of cycles. Finished results are committed to two private 32-bit registers, HI and LO. The pipeline reads them later through a dedicated read port that mirrors the move-from-HI and move-from-LO instructions.

The signed variants work on magnitudes and restore the signs at the end. A multiply fills HI:LO with the 64-bit product. A divide places the quotient in LO and the remainder in HI. While an operation is in flight the unit reports busy. A read request that arrives during that time raises a stall, which the core uses to hold the reading instruction until the new values have been committed.

Top module: `muldiv_hilo`

## Requirements
- R1: With `op` = 2'b01 (bit 1 = 0 selects multiply, bit 0 = 1 selects unsigned), the 64-bit unsigned product of `opa` and `opb` is committed: HI gets bits 63:32 and LO gets bits 31:0.
- R2: With `op` = 2'b00, `opa` and `opb` are read as two's complement. HI:LO receives their signed 64-bit product, including the case -2^31 times -1.
- R3: With `op` = 2'b11 (bit 1 = 1 selects divide) and a nonzero `opb`, LO gets the unsigned quotient `opa`/`opb` and HI gets the unsigned remainder.
- R4: With `op` = 2'b10 and a nonzero `opb`, the quotient is truncated toward zero and is negative when the operand signs differ. The remainder carries the sign of `opa`. -2^31 divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: A divide with `opb` = 0, signed or unsigned, completes normally with LO = 0xFFFFFFFF and HI = `opa`.
- R6: `busy` is high from the edge that accepts a start (a rising edge with `start` high while `busy` is low) until the 33rd edge after it. On that edge HI and LO are written and `busy` falls. HI and LO change at no other time.
- R7: `stall` is high exactly when `rd_req` is high while `busy` is high.
- R8: A start request while `busy` is high is ignored: the running operation's result and completion time are unchanged.
- R9: `rd_data` shows HI when `rd_sel` = 1 and LO when `rd_sel` = 0, taken directly from the result registers.
- R10: After synchronous reset, HI and LO are zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request for a new operation |
| op | input | 2 | Bit 1: divide (1) or multiply (0); bit 0: unsigned (1) or signed (0) |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| rd_req | input | 1 | Read request from a move-from instruction |
| rd_sel | input | 1 | 1 reads HI, 0 reads LO |
| busy | output | 1 | Operation in flight |
| stall | output | 1 | Read request must wait |
| rd_data | output | 32 | Selected result register |

## Verification
Counting from the edge that accepts a start, `busy` is due high right after that edge and is due low, with new HI and LO, right after the 33rd edge that follows. The bench drives inputs on falling edges and samples every output half a cycle after a rising edge. It checks `busy` is still high after edge 32 and low after edge 33, and reads HI and LO only after that. Checks of `stall` and of the unchanged HI/LO are made at a midpoint of the run. The read port is combinational from the registers, so the bench samples `rd_data` one time step after changing `rd_sel`.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  // sequencer phases
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ITER   = 2'd1,
    PH_COMMIT = 2'd2
  } phase_t;

  // bit positions within the operation code
  localparam int OPB_UNS = 0;
  localparam int OPB_DIV = 1;
endpackage

// File: rtl/muldiv_prep.sv
// Converts operands to magnitudes and records their signs.
module muldiv_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_uns,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_a,
  output logic         neg_b
);
  always_comb begin
    neg_a = !is_uns && a[W-1];
    neg_b = !is_uns && b[W-1];
    mag_a = neg_a ? (~a + W'(1)) : a;
    mag_b = neg_b ? (~b + W'(1)) : b;
  end
endmodule

// File: rtl/muldiv_step.sv
// One iteration: shift-add for multiply, restoring step for divide.
// Work register layout: [2W:W] upper part (accumulator or partial
// remainder), [W-1:0] lower part (multiplier or dividend/quotient).
module muldiv_step #(
  parameter int W = 32
) (
  input  logic [2*W:0] work,
  input  logic         is_div,
  input  logic [W-1:0] m,
  output logic [2*W:0] work_nx
);
  logic [W:0]   sum;
  logic [W:0]   shifted;
  logic [W:0]   diff;
  logic         fits;
  logic [2*W:0] nx_mul;
  logic [2*W:0] nx_div;

  always_comb begin
    // multiply: add multiplicand when the current multiplier bit is set
    sum    = work[2*W:W] + (work[0] ? {1'b0, m} : '0);
    nx_mul = {1'b0, sum, work[W-1:1]};
    // divide: bring in next dividend bit, trial subtract, restore on borrow
    shifted = {work[2*W-1:W], work[W-1]};
    diff    = shifted - {1'b0, m};
    fits    = !diff[W];
    nx_div  = {(fits ? diff : shifted), work[W-2:0], fits};
    work_nx = is_div ? nx_div : nx_mul;
  end
endmodule

// File: rtl/muldiv_fix.sv
// Restores result signs and forms the HI/LO values to commit.
module muldiv_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  input  logic         is_div,
  input  logic         neg_a,
  input  logic         neg_b,
  input  logic         b_zero,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic [2*W-1:0] prod;
  logic [2*W-1:0] prod_neg;
  logic [W-1:0]   quo;
  logic [W-1:0]   rem;

  always_comb begin
    prod     = {raw_hi, raw_lo};
    prod_neg = ~prod + (2*W)'(1);
    // a zero divisor leaves the all-ones quotient untouched
    quo = (neg_a ^ neg_b) && !b_zero ? (~raw_lo + W'(1)) : raw_lo;
    rem = neg_a ? (~raw_hi + W'(1)) : raw_hi;
    if (is_div) begin
      hi = rem;
      lo = quo;
    end else begin
      hi = (neg_a ^ neg_b) ? prod_neg[2*W-1:W] : prod[2*W-1:W];
      lo = (neg_a ^ neg_b) ? prod_neg[W-1:0]   : prod[W-1:0];
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         rd_req,
  input  logic         rd_sel,
  output logic         busy,
  output logic         stall,
  output logic [W-1:0] rd_data
);
  localparam int CW = $clog2(W);
  localparam int AW = 2 * W + 1;

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] work_q;
  logic [AW-1:0] work_nx;
  logic [W-1:0]  m_q;
  logic          is_div_q;
  logic          neg_a_q;
  logic          neg_b_q;
  logic          b_zero_q;
  logic [W-1:0]  hi_q;
  logic [W-1:0]  lo_q;

  logic [W-1:0]  mag_a;
  logic [W-1:0]  mag_b;
  logic          neg_a;
  logic          neg_b;
  logic [W-1:0]  fix_hi;
  logic [W-1:0]  fix_lo;
  logic          op_div;

  assign op_div = op[OPB_DIV];

  muldiv_prep #(.W(W)) u_prep (
    .a      (opa),
    .b      (opb),
    .is_uns (op[OPB_UNS]),
    .mag_a  (mag_a),
    .mag_b  (mag_b),
    .neg_a  (neg_a),
    .neg_b  (neg_b)
  );

  muldiv_step #(.W(W)) u_step (
    .work    (work_q),
    .is_div  (is_div_q),
    .m       (m_q),
    .work_nx (work_nx)
  );

  muldiv_fix #(.W(W)) u_fix (
    .raw_hi (work_q[2*W-1:W]),
    .raw_lo (work_q[W-1:0]),
    .is_div (is_div_q),
    .neg_a  (neg_a_q),
    .neg_b  (neg_b_q),
    .b_zero (b_zero_q),
    .hi     (fix_hi),
    .lo     (fix_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      work_q   <= '0;
      m_q      <= '0;
      is_div_q <= 1'b0;
      neg_a_q  <= 1'b0;
      neg_b_q  <= 1'b0;
      b_zero_q <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            // setup: magnitudes in, multiplier or dividend in the low half
            work_q   <= {{(W+1){1'b0}}, (op_div ? mag_a : mag_b)};
            m_q      <= op_div ? mag_b : mag_a;
            is_div_q <= op_div;
            neg_a_q  <= neg_a;
            neg_b_q  <= neg_b;
            b_zero_q <= (opb == '0);
            cnt_q    <= '0;
            phase_q  <= PH_ITER;
          end
        end
        PH_ITER: begin
          work_q <= work_nx;
          cnt_q  <= cnt_q + CW'(1);
          if (cnt_q == CW'(W - 1)) phase_q <= PH_COMMIT;
        end
        PH_COMMIT: begin
          hi_q    <= fix_hi;
          lo_q    <= fix_lo;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy    = (phase_q != PH_IDLE);
  assign stall   = rd_req && busy;
  assign rd_data = rd_sel ? hi_q : lo_q;
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int CYW = $clog2(W + 3) + 1;

  // cycles since the accepting edge
  logic [CYW-1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)             cyc <= '0;
    else if (busy)       cyc <= cyc + CYW'(1);
    else if (start)      cyc <= CYW'(1);
    else                 cyc <= '0;
  end

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
    !busy && start |=> busy); // R6
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cyc == CYW'(W + 2)); // R6
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    busy |-> cyc <= CYW'(W + 1)); // R6
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy && cyc <= CYW'(W) |=> $stable(hi) && $stable(lo)); // R6
  AST_HOLD_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(hi) && $stable(lo)); // R6
  AST_IGNORE_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy && start && cyc <= CYW'(W) |=> busy); // R8
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .hi    (hi_q),
  .lo    (lo_q)
);

// File: tb/muldiv_hilo_test.sv
module muldiv_hilo_test;
  localparam int CLK_P = 10;
  localparam int NV = 15;

  // {op, opa, opb}; op bit 1 = divide, bit 0 = unsigned
  localparam logic [65:0] VEC [NV] = '{
    {2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {2'b01, 32'h12345678, 32'h9ABCDEF0},
    {2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {2'b00, 32'h80000000, 32'hFFFFFFFF},
    {2'b00, 32'h7FFFFFFF, 32'h80000000},
    {2'b00, 32'hFFFFFFF9, 32'h00000003},
    {2'b11, 32'd100,      32'd7},
    {2'b11, 32'hFFFFFFFF, 32'd10},
    {2'b11, 32'd3,        32'd9},
    {2'b10, 32'hFFFFFFF9, 32'd2},
    {2'b10, 32'd7,        32'hFFFFFFFE},
    {2'b10, 32'hFFFFFFF9, 32'hFFFFFFFE},
    {2'b10, 32'h80000000, 32'hFFFFFFFF},
    {2'b11, 32'd5,        32'd0},
    {2'b10, 32'hFFFFFFFB, 32'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        rd_req = 1'b0;
  logic        rd_sel = 1'b0;
  logic        busy;
  logic        stall;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_P / 2) clk = ~clk;

  muldiv_hilo #(.W(32)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .rd_req(rd_req), .rd_sel(rd_sel), .busy(busy), .stall(stall),
    .rd_data(rd_data)
  );

  function automatic logic [63:0] model(logic [1:0] o, logic [31:0] a, logic [31:0] b);
    logic [31:0] ma, mb, q, r;
    if (!o[1]) begin
      if (o[0]) return {32'b0, a} * {32'b0, b};
      return {{32{a[31]}}, a} * {{32{b[31]}}, b};
    end
    if (b == 0) return {a, 32'hFFFFFFFF};
    if (o[0]) return {a % b, a / b};
    ma = a[31] ? -a : a;
    mb = b[31] ? -b : b;
    q = ma / mb;
    r = ma % mb;
    if (a[31] ^ b[31]) q = -q;
    if (a[31]) r = -r;
    return {r, q};
  endfunction

  function automatic string tag_of(logic [1:0] o, logic [31:0] b);
    if (!o[1]) return o[0] ? "R1" : "R2";
    if (b == 0) return "R5";
    return o[0] ? "R3" : "R4";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_hilo(output logic [31:0] h, output logic [31:0] l);
    rd_sel = 1'b1;
    #1 h = rd_data;
    rd_sel = 1'b0;
    #1 l = rd_data;
  endtask

  // launch at a falling edge; returns after the edge that accepted it
  task automatic launch(logic [1:0] o, logic [31:0] a, logic [31:0] b);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(logic [1:0] o, logic [31:0] a, logic [31:0] b, string tag);
    logic [31:0] h, l;
    logic [63:0] e;
    e = model(o, a, b);
    launch(o, a, b);
    chk("R6 busy after accept", 32'(busy), 32'd1);
    repeat (32) @(negedge clk);
    chk("R6 busy after edge 32", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R6 busy after edge 33", 32'(busy), 32'd0);
    read_hilo(h, l);
    chk($sformatf("%s R9 HI %h,%h", tag, a, b), h, e[63:32]);
    chk($sformatf("%s R9 LO %h,%h", tag, a, b), l, e[31:0]);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog R6: got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] h, l, h0, l0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk("R10 busy", 32'(busy), 32'd0);
    chk("R7 stall idle", 32'(stall), 32'd0);
    read_hilo(h, l);
    chk("R10/R9 HI", h, 32'd0);
    chk("R10/R9 LO", l, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0],
             tag_of(VEC[i][65:64], VEC[i][31:0]));
      @(negedge clk);
    end

    // idle: no start, registers hold (last op: -5 / 0)
    repeat (5) @(negedge clk);
    read_hilo(h0, l0);
    chk("R6 idle hold HI", h0, 32'hFFFFFFFB);
    chk("R6 idle hold LO", l0, 32'hFFFFFFFF);

    // restart while busy is ignored; stall while busy; old values visible
    launch(2'b01, 32'd3, 32'd5);
    repeat (5) @(negedge clk);
    rd_req = 1'b1;
    rd_sel = 1'b0;
    #1;
    chk("R7 stall while busy", 32'(stall), 32'd1);
    chk("R6 LO unchanged while busy", rd_data, l0);
    start = 1'b1; op = 2'b11; opa = 32'd100; opb = 32'd7;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy kept", 32'(busy), 32'd1);
    repeat (26) @(negedge clk);
    chk("R8 busy after edge 32", 32'(busy), 32'd1);
    chk("R7 stall late", 32'(stall), 32'd1);
    @(negedge clk);
    chk("R8 busy after edge 33", 32'(busy), 32'd0);
    chk("R7 stall released", 32'(stall), 32'd0);
    rd_req = 1'b0;
    read_hilo(h, l);
    chk("R8 HI of first op", h, 32'd0);
    chk("R8 LO of first op", l, 32'd15);

    // read request while idle gives no stall
    rd_req = 1'b1;
    #1 chk("R7 idle read", 32'(stall), 32'd0);
    rd_req = 1'b0;

    // reset mid-operation clears everything
    launch(2'b00, 32'hFFFFFFFF, 32'd2);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 busy after mid reset", 32'(busy), 32'd0);
    read_hilo(h, l);
    chk("R10 HI after mid reset", h, 32'd0);
    chk("R10 LO after mid reset", l, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule